// File: doc/BRIEF.md
# Masked Atomic Swap Unit

This unit carries out a read-merge-write on one 32-bit memory word. The merge lets any subset of the word's bits act as independent semaphores. It takes a 64-bit operand pair: the low half holds the new bit values and the high half holds the selection mask. It reads the addressed word and writes back a word that keeps the old bits where the mask is clear and takes the operand bits where the mask is set. The full, unmodified old word is returned as the register result, whatever the mask.

The unit decodes a 32-bit instruction word in one of three addressing forms:

- **Base plus signed offset**: the address is the base plus a sign-extended 10-bit offset.
- **Bit-reversed index**: the address is the base plus a 16-bit index, and the index then steps in bit-reversed order.
- **Circular index**: the address is the base plus a 16-bit index, and the index then moves by the signed offset and wraps within a buffer length.

The two indexed forms return an updated index/modifier word for the caller to write back. The read and the write run as one locked sequence on a single-port memory handshake. Any other instruction is flagged as illegal and touches no memory.

Top module: `masked_swap_unit`

## Requirements
- R1: The word written back equals (old AND NOT mask) OR (data AND mask), where data = `reg_pair[31:0]` and mask = `reg_pair[63:32]`.
- R2: On completion `done` is high for exactly one cycle. While it is high, `result` holds the full old memory word and `result_idx` holds instruction bits [11:8].
- R3: Instruction field layout: major opcode in bits [7:0], data-register index in [11:8], address-register index in [15:12], offset[5:0] in [21:16], secondary opcode in [27:22], offset[9:6] in [31:28]. When the major opcode is 0x49 and the secondary opcode is 0x22, the access address is `base_addr` plus the sign-extended 10-bit offset, and `upd_en` stays low.
- R4: When the major opcode is 0x69 and the secondary opcode is 0x02, the address is `base_addr` plus zero-extended `addr_mod[15:0]`. With `done`, `upd_en` is high and `upd_value` = {incr, rev16(rev16(index)+rev16(incr))}, where incr = `addr_mod[31:16]`.
- R5: When the major opcode is 0x69 and the secondary opcode is 0x12, the address is `base_addr` plus `addr_mod[15:0]`. With `done`, `upd_value` = {length, new index}, where length = `addr_mod[31:16]`. The new index is index + sign-extended offset, plus length if the sum is negative, or minus length if the sum is at least length.
- R6: Each accepted instruction makes exactly one read and then exactly one write, both to the same address. `mem_lock` is high on every cycle that `mem_req` is high, and it falls only after the write is acknowledged.
- R7: An all-zero mask still reads the word, returns it as the result, and writes it back unchanged.
- R8: Any other opcode combination pulses `illegal` for one cycle and raises no `mem_req` and no `done`.
- R9: After reset, `mem_req`, `mem_lock`, `busy`, `done` and `illegal` are all low.
- R10: `start` is ignored while `busy` is high.
- R11: A pending request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Instruction valid, taken when idle |
| instr | input | 32 | Instruction word |
| reg_pair | input | 64 | Mask in [63:32], swap data in [31:0] |
| base_addr | input | 32 | Base address register value |
| addr_mod | input | 32 | Index in [15:0], increment or length in [31:16] |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Merged write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Request accepted or completed this cycle |
| mem_lock | output | 1 | Holds off other masters during the sequence |
| busy | output | 1 | Unit is executing |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| result | output | 32 | Old memory word for the data register |
| result_idx | output | 4 | Destination data-register index |
| areg_idx | output | 4 | Address-register index from the instruction |
| upd_en | output | 1 | `upd_value` is valid (indexed forms, with `done`) |
| upd_value | output | 32 | New index/modifier word |

## Verification
On every cycle, assertions check four things:

- the merged write data keeps the unmasked old bits and takes the masked operand bits;
- a read acknowledgement is followed at once by a write to the same address;
- requests, and the captured operands during busy, hold steady until acknowledged;
- `done` is a single-cycle pulse, and `illegal` never coincides with a request or with `done`.

Other properties can only be shown by the bench's sweeps. These are the computed addresses and index updates of all three forms, circular wrap in both directions, and bit-reversed stepping. They also include the exact count of one read and one write per instruction, memory left intact outside the target word, and `start` ignored mid-operation.

// File: rtl/mswp_pkg.sv
package mswp_pkg;

  localparam int INSN_W  = 32;
  localparam int OFF_W   = 10;
  localparam int RIDX_W  = 4;

  localparam logic [7:0] MAJ_BASE = 8'h49;
  localparam logic [7:0] MAJ_IDX  = 8'h69;
  localparam logic [5:0] SUB_BASE = 6'h22;
  localparam logic [5:0] SUB_BREV = 6'h02;
  localparam logic [5:0] SUB_CIRC = 6'h12;

  typedef enum logic [1:0] {
    AM_BASE_OFF = 2'd0,
    AM_BIT_REV  = 2'd1,
    AM_CIRC     = 2'd2,
    AM_NONE     = 2'd3
  } amode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } st_t;

  typedef struct packed {
    amode_t              mode;
    logic [RIDX_W-1:0]   didx;
    logic [RIDX_W-1:0]   aidx;
    logic [OFF_W-1:0]    off;
  } dec_t;

endpackage

// File: rtl/mswp_decode.sv
module mswp_decode
  import mswp_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec,
  output logic              legal
);

  logic [7:0] major;
  logic [5:0] minor;

  assign major = instr[7:0];
  assign minor = instr[27:22];

  always_comb begin
    dec.didx = instr[11:8];
    dec.aidx = instr[15:12];
    dec.off  = {instr[31:28], instr[21:16]};
    if (major == MAJ_BASE && minor == SUB_BASE) begin
      dec.mode = AM_BASE_OFF;
    end else if (major == MAJ_IDX && minor == SUB_BREV) begin
      dec.mode = AM_BIT_REV;
    end else if (major == MAJ_IDX && minor == SUB_CIRC) begin
      dec.mode = AM_CIRC;
    end else begin
      dec.mode = AM_NONE;
    end
    legal = (dec.mode != AM_NONE);
  end

endmodule

// File: rtl/mswp_agen.sv
module mswp_agen
  import mswp_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int OW = 10
) (
  input  amode_t          mode,
  input  logic [AW-1:0]   base,
  input  logic [2*IW-1:0] amod,
  input  logic [OW-1:0]   off,
  output logic [AW-1:0]   ea,
  output logic [2*IW-1:0] upd,
  output logic            upd_en
);

  localparam int SW = IW + 2;

  logic [IW-1:0] idx;
  logic [IW-1:0] hi;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] idx_ext;
  logic [IW-1:0] rev_step;
  logic [SW-1:0] c_sum;
  logic [SW-1:0] c_len;
  logic [SW-1:0] c_wrap;

  function automatic logic [IW-1:0] flip(input logic [IW-1:0] v);
    logic [IW-1:0] r;
    for (int i = 0; i < IW; i++) r[i] = v[IW-1-i];
    return r;
  endfunction

  assign idx     = amod[IW-1:0];
  assign hi      = amod[2*IW-1:IW];
  assign off_ext = {{(AW-OW){off[OW-1]}}, off};
  assign idx_ext = {{(AW-IW){1'b0}}, idx};

  assign rev_step = flip(flip(idx) + flip(hi));

  assign c_sum = {2'b00, idx} + {{(SW-OW){off[OW-1]}}, off};
  assign c_len = {2'b00, hi};

  always_comb begin
    if (c_sum[SW-1]) begin
      c_wrap = c_sum + c_len;
    end else if (c_sum >= c_len) begin
      c_wrap = c_sum - c_len;
    end else begin
      c_wrap = c_sum;
    end
  end

  always_comb begin
    ea     = base + idx_ext;
    upd    = amod;
    upd_en = 1'b0;
    case (mode)
      AM_BASE_OFF: ea = base + off_ext;
      AM_BIT_REV: begin
        upd    = {hi, rev_step};
        upd_en = 1'b1;
      end
      AM_CIRC: begin
        upd    = {hi, c_wrap[IW-1:0]};
        upd_en = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mswp_merge.sv
module mswp_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] new_bits,
  input  logic [DW-1:0] sel,
  output logic [DW-1:0] merged
);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign merged[i] = sel[i] ? new_bits[i] : old_word[i];
  end

endmodule

// File: rtl/masked_swap_unit.sv
module masked_swap_unit
  import mswp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [2*DW-1:0] reg_pair,
  input  logic [AW-1:0]   base_addr,
  input  logic [2*IW-1:0] addr_mod,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            mem_lock,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [DW-1:0]   result,
  output logic [3:0]      result_idx,
  output logic [3:0]      areg_idx,
  output logic            upd_en,
  output logic [2*IW-1:0] upd_value
);

  logic [1:0]       rs_q;
  logic             rst_s_n;
  st_t              state_q, state_d;
  dec_t             dec;
  logic             legal;
  logic [AW-1:0]    ea;
  logic [2*IW-1:0]  upd;
  logic             upd_en_c;
  logic             accept;
  logic             old_en;
  logic             ill_d, ill_q;
  logic [AW-1:0]    ea_q;
  logic [DW-1:0]    data_q, mask_q, old_q;
  logic [3:0]       didx_q, aidx_q;
  logic [2*IW-1:0]  upd_q;
  logic             upd_en_q;
  logic [DW-1:0]    merged;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  mswp_decode u_dec (
    .instr (instr),
    .dec   (dec),
    .legal (legal)
  );

  mswp_agen #(.AW(AW), .IW(IW), .OW(OFF_W)) u_agen (
    .mode   (dec.mode),
    .base   (base_addr),
    .amod   (addr_mod),
    .off    (dec.off),
    .ea     (ea),
    .upd    (upd),
    .upd_en (upd_en_c)
  );

  mswp_merge #(.DW(DW)) u_merge (
    .old_word (old_q),
    .new_bits (data_q),
    .sel      (mask_q),
    .merged   (merged)
  );

  assign accept = (state_q == ST_IDLE) && start && legal;
  assign ill_d  = (state_q == ST_IDLE) && start && !legal;
  assign old_en = (state_q == ST_READ) && mem_ack;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)  state_d = ST_READ;
      ST_READ:  if (mem_ack) state_d = ST_WRITE;
      ST_WRITE: if (mem_ack) state_d = ST_DONE;
      default:               state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
    end
  end

  // operand capture, enabled only on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      ea_q     <= ea;
      data_q   <= reg_pair[DW-1:0];
      mask_q   <= reg_pair[2*DW-1:DW];
      didx_q   <= dec.didx;
      aidx_q   <= dec.aidx;
      upd_q    <= upd;
      upd_en_q <= upd_en_c;
    end
  end

  // old word capture, enabled on read acknowledge
  always_ff @(posedge clk) begin
    if (old_en) old_q <= mem_rdata;
  end

  assign mem_req    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we     = (state_q == ST_WRITE);
  assign mem_lock   = mem_req;
  assign mem_addr   = ea_q;
  assign mem_wdata  = merged;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign illegal    = ill_q;
  assign result     = old_q;
  assign result_idx = didx_q;
  assign areg_idx   = aidx_q;
  assign upd_en     = done && upd_en_q;
  assign upd_value  = upd_q;

  AST_MERGE_BITS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_WRITE) |-> ((((mem_wdata ^ old_q) & ~mask_q) == '0) &&
                               (((mem_wdata ^ data_q) & mask_q) == '0))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done); // R2
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr))); // R6
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(mem_lock) |-> $past(mem_we && mem_ack)); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    illegal |-> (!mem_req && !done)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && $past(busy)) |-> ($stable(data_q) && $stable(mask_q) && $stable(ea_q))); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R11

endmodule

// File: tb/sim_masked_swap_unit.sv
`timescale 1ns/1ps
module sim_masked_swap_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] instr;
  logic [63:0] reg_pair;
  logic [31:0] base_addr;
  logic [31:0] addr_mod;
  logic        mem_req, mem_we, mem_ack, mem_lock;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, illegal, upd_en;
  logic [31:0] result, upd_value;
  logic [3:0]  result_idx, areg_idx;

  int checks;
  int errors;

  // memory model
  logic [31:0] mem [16];
  logic        slow;
  int          stall;
  int          rd_n, wr_n, nolock_n;
  logic [31:0] rd_addr, wr_addr;
  logic        pl_en;
  logic [3:0]  pl_idx;
  logic [31:0] pl_val;

  masked_swap_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .reg_pair(reg_pair), .base_addr(base_addr), .addr_mod(addr_mod),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_lock(mem_lock), .busy(busy), .done(done), .illegal(illegal),
    .result(result), .result_idx(result_idx), .areg_idx(areg_idx),
    .upd_en(upd_en), .upd_value(upd_value)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:2]];
  assign mem_ack   = mem_req && (!slow || stall == 2);

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_val;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[5:2]] <= mem_wdata;
        wr_n    <= wr_n + 1;
        wr_addr <= mem_addr;
      end else begin
        rd_n    <= rd_n + 1;
        rd_addr <= mem_addr;
      end
    end
    if (mem_req && !mem_lock) nolock_n <= nolock_n + 1;
    stall <= (mem_req && !mem_ack) ? stall + 1 : 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rv(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] maj, input logic [5:0] sub,
                                     input logic [9:0] off, input logic [3:0] a, input logic [3:0] b);
    return {off[9:6], sub, off[5:0], b, a, maj};
  endfunction

  logic [31:0] sh [16];
  int opn;

  task automatic do_op(input logic [31:0] ins, input logic [63:0] pair,
                       input logic [31:0] base, input logic [31:0] amod,
                       input bit exp_ill, input logic [31:0] exp_addr,
                       input bit exp_uen, input logic [31:0] exp_upd,
                       input bit poke, input string areq);
    int rd0, wr0, nl0, extra_ill;
    bit got_done, got_ill;
    logic [31:0] res, uval, mrg, mask;
    logic [3:0] ridx, aidx;
    logic uen;
    int ti;
    opn++;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sh[i]  = (32'h9E3779B9 * (i + 1)) ^ (32'h85EBCA6B * opn);
      pl_en  = 1'b1;
      pl_idx = 4'(i);
      pl_val = sh[i];
    end
    @(negedge clk);
    pl_en = 1'b0;
    rd0 = rd_n; wr0 = wr_n; nl0 = nolock_n;
    got_done = 0; got_ill = 0; extra_ill = 0;
    res = '0; uval = '0; uen = 0; ridx = '0; aidx = '0;
    start = 1'b1; instr = ins; reg_pair = pair; base_addr = base; addr_mod = amod;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) begin
        got_done = 1; res = result; ridx = result_idx; aidx = areg_idx;
        uen = upd_en; uval = upd_value;
      end
      if (illegal) got_ill = 1;
      if (k == 0) start = 1'b0;
      if (poke && k == 1) begin
        start = 1'b1;
        instr = mk(8'h00, 6'h3F, 10'h0, 4'h1, 4'h2);
        reg_pair = 64'hFFFFFFFF_00000000;
      end
      if (poke && k == 2) start = 1'b0;
      if (got_done || got_ill) begin
        start = 1'b0;
        break;
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (illegal) extra_ill++;
      if (done) got_done = 1;
    end
    mask = pair[63:32];
    if (exp_ill) begin
      chk(got_ill, "R8 illegal pulse", 32'(got_ill), 32'd1);
      chk(!got_done, "R8 no done", 32'(got_done), 32'd0);
      chk(rd_n == rd0 && wr_n == wr0, "R8 no memory access", 32'(rd_n - rd0 + wr_n - wr0), 32'd0);
      for (int i = 0; i < 16; i++)
        if (mem[i] != sh[i]) chk(0, "R8 memory intact", mem[i], sh[i]);
    end else begin
      ti  = int'(exp_addr[5:2]);
      mrg = (sh[ti] & ~mask) | (pair[31:0] & mask);
      chk(got_done && !got_ill, "R2 completion", 32'(got_done), 32'd1);
      chk(res == sh[ti], "R2 old word returned", res, sh[ti]);
      chk(ridx == ins[11:8] && aidx == ins[15:12], "R2 register indices", {24'h0, aidx, ridx}, {24'h0, ins[15:8]});
      chk(rd_n - rd0 == 1 && wr_n - wr0 == 1, "R6 one read one write", 32'((rd_n - rd0) * 16 + wr_n - wr0), 32'h11);
      chk(rd_addr == exp_addr, areq, rd_addr, exp_addr);
      chk(wr_addr == rd_addr, "R6 write same address", wr_addr, rd_addr);
      chk(nolock_n == nl0, "R6 lock during request", 32'(nolock_n - nl0), 32'd0);
      if (mask == 32'h0) chk(mem[ti] == sh[ti], "R7 zero mask unchanged", mem[ti], sh[ti]);
      else               chk(mem[ti] == mrg, "R1 merged word", mem[ti], mrg);
      for (int i = 0; i < 16; i++)
        if (i != ti && mem[i] != sh[i]) chk(0, "R6 other words intact", mem[i], sh[i]);
      chk(uen == exp_uen, exp_uen ? areq : "R3 no update", 32'(uen), 32'(exp_uen));
      if (exp_uen) chk(uval == exp_upd, areq, uval, exp_upd);
      if (poke) chk(extra_ill == 0 && !got_ill, "R10 start ignored while busy", 32'(extra_ill), 32'd0);
    end
  endtask

  initial begin
    checks = 0; errors = 0; opn = 0;
    rd_n = 0; wr_n = 0; nolock_n = 0; stall = 0; slow = 1'b0;
    pl_en = 1'b0; pl_idx = '0; pl_val = '0;
    start = 1'b0; instr = '0; reg_pair = '0; base_addr = '0; addr_mod = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!mem_req && !mem_lock && !busy && !done && !illegal, "R9 state in reset",
        {27'h0, mem_req, mem_lock, busy, done, illegal}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !mem_lock && !busy && !done && !illegal, "R9 state after reset",
        {27'h0, mem_req, mem_lock, busy, done, illegal}, 32'h0);

    // base plus offset sweep, offsets -32..28
    for (int j = 0; j < 16; j++) begin
      logic [9:0]  off;
      logic [31:0] m;
      off = 10'(-32 + 4 * j);
      case (j % 4)
        0: m = 32'hFFFF_FFFF;
        1: m = 32'h0;
        2: m = 32'h0F0F_0F0F;
        default: m = 32'h1 << j;
      endcase
      do_op(mk(8'h49, 6'h22, off, 4'(j), 4'(15 - j)), {m, 32'hC3A5_5A3C ^ (32'h1111 * j)},
            32'd32, 32'hDEAD_BEEF, 0, 32'(32 - 32 + 4 * j), 0, 32'h0, 0, "R3 base+offset address");
    end

    // bit-reversed index sweep
    for (int j = 0; j < 16; j++) begin
      logic [15:0] idx, inc, nidx;
      idx  = 16'(4 * j);
      inc  = (j % 2 == 0) ? 16'h0020 : 16'h0004;
      nidx = rv(rv(idx) + rv(inc));
      do_op(mk(8'h69, 6'h02, 10'h0, 4'h3, 4'h4), {32'hAAAA_5555, 32'h1234_5678 + j},
            32'd0, {inc, idx}, 0, 32'(idx), 1, {inc, nidx}, 0, "R4 bit-reverse");
    end

    // circular sweep with wrap both ways
    for (int j = 0; j < 16; j++) begin
      int s, o;
      logic [15:0] idx, len;
      idx = 16'(4 * j);
      len = 16'd64;
      case (j % 4)
        0: o = 8;
        1: o = -8;
        2: o = 28;
        default: o = -28;
      endcase
      s = int'(idx) + o;
      if (s < 0) s = s + int'(len);
      else if (s >= int'(len)) s = s - int'(len);
      do_op(mk(8'h69, 6'h12, 10'(o), 4'h5, 4'h6), {(j == 5) ? 32'h0 : 32'hF00F_1234, 32'h0BAD_F00D},
            32'd0, {len, idx}, 0, 32'(idx), 1, {len, 16'(s)}, 0, "R5 circular");
    end

    // wait states on the memory
    slow = 1'b1;
    for (int j = 0; j < 4; j++)
      do_op(mk(8'h49, 6'h22, 10'(4 * j), 4'h7, 4'h8), {32'h00FF_00FF, 32'h7777_0000 + j},
            32'd8, 32'h0, 0, 32'(8 + 4 * j), 0, 32'h0, 0, "R11 address with wait states");
    slow = 1'b0;

    // illegal encodings
    do_op(mk(8'h49, 6'h02, 10'h0, 4'h1, 4'h1), 64'hFFFFFFFF_FFFFFFFF, 32'd0, 32'h0, 1, 32'h0, 0, 32'h0, 0, "R8");
    do_op(mk(8'h69, 6'h22, 10'h0, 4'h1, 4'h1), 64'hFFFFFFFF_FFFFFFFF, 32'd0, 32'h0, 1, 32'h0, 0, 32'h0, 0, "R8");
    do_op(mk(8'h49, 6'h12, 10'h4, 4'h1, 4'h1), 64'hFFFFFFFF_FFFFFFFF, 32'd0, 32'h0, 1, 32'h0, 0, 32'h0, 0, "R8");
    do_op(mk(8'h00, 6'h22, 10'h4, 4'h1, 4'h1), 64'hFFFFFFFF_FFFFFFFF, 32'd0, 32'h0, 1, 32'h0, 0, 32'h0, 0, "R8");

    // start while busy
    do_op(mk(8'h49, 6'h22, 10'h8, 4'h9, 4'hA), {32'hFFFF_0000, 32'h1357_9BDF},
          32'd16, 32'h0, 0, 32'd24, 0, 32'h0, 1, "R10 address");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all) actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule